// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out where a 32-bit RISC core fetches next. One request carries the current program counter and a decoded control-transfer kind. It also carries two register operand values, a 16-bit branch immediate and a 26-bit jump target field. From these the block produces the following program counter. For the linking jumps it also produces a return-address write aimed at register 31.

The block supports straight-line fetch, taken and not-taken conditional branches, and jumps. Conditional branches either compare two registers or test one register against zero. Jumps are absolute within the current 256 MiB region or go through a register, each with or without a link. Requests enter on a valid/ready port and results leave on a valid/ready port through a single register stage. The result of an accepted request appears on the output one clock later. The unit accepts a request whenever its output register is empty or is being drained in the same cycle. While the downstream side holds `res_ready` low, the output stays frozen and no new request is taken.

Top module: `npc_unit`

## Requirements
- R1: Kind code 0 (sequential), and every unused code 11 to 15, gives next PC = PC + 4 with no link write.
- R2: Kind 1 (equal) and kind 2 (not equal) compare `req_opa` with `req_opb`. When the branch is taken, next PC = PC + 4 + (sign-extended immediate shifted left by 2). When it is not taken, next PC = PC + 4.
- R3: Kinds 3 (≥0), 4 (≤0), 5 (<0) and 6 (>0) test `req_opa` as a two's complement value against zero. A zero operand satisfies ≥0 and ≤0 only. Taken and not-taken targets follow the R2 rules.
- R4: Kinds 7 (absolute jump) and 8 (absolute jump with link) give next PC = {PC[31:28], target field, 2'b00}.
- R5: Kinds 9 (register jump) and 10 (register jump with link) give next PC = `req_opa`, passed through unaltered.
- R6: Kinds 8 and 10 raise `res_link_we` with `res_link_idx` = 31 and `res_link_val` = PC + 4. All other kinds, including every branch, leave `res_link_we` low. One link write is made per linking jump: the one that accompanies its single output handshake.
- R7: All PC additions wrap modulo 2^32.
- R8: `req_ready` is high whenever `res_valid` is low or `res_ready` is high. The result of a request accepted on one edge is valid after that edge. While `res_valid` is high and `res_ready` is low, all result outputs hold their values.
- R9: After reset, `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_pc | input | 32 | Program counter of the current instruction |
| req_kind | input | 4 | Control-transfer kind code (see R1 to R6) |
| req_opa | input | 32 | First register operand (compared, tested or jumped to) |
| req_opb | input | 32 | Second register operand (equality branches) |
| req_imm | input | 16 | Branch displacement in words |
| req_tgt | input | 26 | Absolute jump target field |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes the result |
| res_pc | output | 32 | Next program counter |
| res_link_we | output | 1 | Return-address write request |
| res_link_idx | output | 5 | Return-address register index, always 31 |
| res_link_val | output | 32 | Return address |

## Verification
The bench targets the zero operand, on which a design that folds zero into the wrong side would take the <0 or >0 branch or skip the ≥0 or ≤0 branch. It also drives the most negative value, on which a design testing magnitude instead of the sign bit would branch the wrong way. Backward displacements and a PC near the top of memory expose a missing sign extension or missing wraparound. Unaligned register-jump targets show up any design that masks the low bits. Branches that would link, and a stalled output carrying a second waiting request, catch designs that raise spurious link writes or lose or overwrite a held result.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    KIND_SEQ      = 4'd0,
    KIND_BR_EQ    = 4'd1,
    KIND_BR_NE    = 4'd2,
    KIND_BR_GEZ   = 4'd3,
    KIND_BR_LEZ   = 4'd4,
    KIND_BR_LTZ   = 4'd5,
    KIND_BR_GTZ   = 4'd6,
    KIND_JMP      = 4'd7,
    KIND_JMP_LINK = 4'd8,
    KIND_JREG     = 4'd9,
    KIND_JREG_LNK = 4'd10
  } xfer_kind_e;

  // Grouping of the kind codes into target sources
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } pc_src_e;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic              is_branch,
  output logic              taken
);
  logic opa_neg;
  logic opa_zero;
  logic ops_equal;

  assign opa_neg   = opa[XLEN-1];
  assign opa_zero  = (opa == '0);
  assign ops_equal = (opa == opb);

  always_comb begin
    is_branch = 1'b1;
    taken     = 1'b0;
    case (kind)
      KIND_BR_EQ:  taken = ops_equal;
      KIND_BR_NE:  taken = !ops_equal;
      KIND_BR_GEZ: taken = !opa_neg;
      KIND_BR_LEZ: taken = opa_neg || opa_zero;
      KIND_BR_LTZ: taken = opa_neg;
      KIND_BR_GTZ: taken = !opa_neg && !opa_zero;
      default:     is_branch = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [TGT_W-1:0] tgt,
  input  logic [XLEN-1:0]  opa,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  abs_pc,
  output logic [XLEN-1:0]  reg_pc
);
  localparam int ALIGN_W  = 2;
  localparam int REGION_W = XLEN - TGT_W - ALIGN_W;
  localparam int SEXT_W   = XLEN - IMM_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] disp;

  assign seq_pc = pc + STEP;

  generate
    if (SEXT_W > 0) begin : g_sext
      assign disp = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    end else begin : g_trunc
      assign disp = XLEN'({imm, {ALIGN_W{1'b0}}});
    end
  endgenerate

  assign br_pc = seq_pc + disp;

  generate
    if (REGION_W > 0) begin : g_region
      assign abs_pc = {pc[XLEN-1 -: REGION_W], tgt, {ALIGN_W{1'b0}}};
    end else begin : g_flat
      assign abs_pc = XLEN'({tgt, {ALIGN_W{1'b0}}});
    end
  endgenerate

  assign reg_pc = opa;
endmodule

// File: rtl/npc_out_slice.sv
module npc_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R8: a stalled result stays valid and unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 16,
  parameter int TGT_W    = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [XLEN-1:0]   req_pc,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [XLEN-1:0]   req_opa,
  input  logic [XLEN-1:0]   req_opb,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [TGT_W-1:0]  req_tgt,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [XLEN-1:0]   res_pc,
  output logic              res_link_we,
  output logic [IDX_W-1:0]  res_link_idx,
  output logic [XLEN-1:0]   res_link_val
);
  localparam int PAY_W = 2 * XLEN + 1;
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

  logic            br_sel;
  logic            br_taken;
  logic [XLEN-1:0] seq_pc, br_pc, abs_pc, reg_pc;
  pc_src_e         src;
  logic            link_now;
  logic [XLEN-1:0] next_pc;
  logic [PAY_W-1:0] pay_in, pay_out;

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .kind      (req_kind),
    .opa       (req_opa),
    .opb       (req_opb),
    .is_branch (br_sel),
    .taken     (br_taken)
  );

  npc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_tgt (
    .pc     (req_pc),
    .imm    (req_imm),
    .tgt    (req_tgt),
    .opa    (req_opa),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .abs_pc (abs_pc),
    .reg_pc (reg_pc)
  );

  always_comb begin
    src      = SRC_SEQ;
    link_now = 1'b0;
    case (req_kind)
      KIND_JMP:      src = SRC_ABS;
      KIND_JMP_LINK: begin src = SRC_ABS; link_now = 1'b1; end
      KIND_JREG:     src = SRC_REG;
      KIND_JREG_LNK: begin src = SRC_REG; link_now = 1'b1; end
      default:       src = (br_sel && br_taken) ? SRC_BR : SRC_SEQ;
    endcase
  end

  always_comb begin
    case (src)
      SRC_BR:  next_pc = br_pc;
      SRC_ABS: next_pc = abs_pc;
      SRC_REG: next_pc = reg_pc;
      default: next_pc = seq_pc;
    endcase
  end

  assign pay_in = {next_pc, link_now, seq_pc};

  npc_out_slice #(.W(PAY_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (pay_out)
  );

  assign res_pc       = pay_out[PAY_W-1 -: XLEN];
  assign res_link_we  = res_valid && pay_out[XLEN];
  assign res_link_val = pay_out[XLEN-1:0];
  assign res_link_idx = LINK_IDX;

  logic acc;
  assign acc = req_valid && req_ready;

  // R1: sequential fetch advances by one word, no link
  a_r1_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == KIND_SEQ) |=>
      (res_valid && res_pc == $past(req_pc) + XLEN'(4) && !res_link_we));

  // R2: unequal operands never take the equality branch
  a_r2_eq_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind == KIND_BR_EQ && req_opa != req_opb) |=>
      (res_pc == $past(req_pc) + XLEN'(4)));

  // R3: zero satisfies both >=0 and <=0
  a_r3_zero_both: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_kind == KIND_BR_GEZ || req_kind == KIND_BR_LEZ)
         && req_opa == '0 && req_imm != '0) |=>
      (res_pc != $past(req_pc) + XLEN'(4)));

  // R4: absolute jump keeps the region bits of the current PC
  a_r4_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_kind == KIND_JMP || req_kind == KIND_JMP_LINK)) |=>
      (res_pc[XLEN-1 -: XLEN-TGT_W-2] == $past(req_pc[XLEN-1 -: XLEN-TGT_W-2])
       && res_pc[1:0] == 2'b00));

  // R5: register jump passes the operand through
  a_r5_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_kind == KIND_JREG || req_kind == KIND_JREG_LNK)) |=>
      (res_pc == $past(req_opa)));

  // R6: linking jumps write the return address, branches never link
  a_r6_link_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_kind == KIND_JMP_LINK || req_kind == KIND_JREG_LNK)) |=>
      (res_link_we && res_link_val == $past(req_pc) + XLEN'(4)));

  a_r6_branch_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_kind >= KIND_BR_EQ && req_kind <= KIND_BR_GTZ) |=> !res_link_we);
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic [3:0]  req_kind = '0;
  logic [31:0] req_opa = '0;
  logic [31:0] req_opb = '0;
  logic [15:0] req_imm = '0;
  logic [25:0] req_tgt = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_pc;
  logic        res_link_we;
  logic [4:0]  res_link_idx;
  logic [31:0] res_link_val;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  npc_unit u0 (.*);

  function automatic logic [31:0] ref_pc(input logic [3:0] k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
      input logic [25:0] tgt);
    logic [31:0] nxt, br;
    nxt = pc + 32'd4;
    br  = nxt + {{14{imm[15]}}, imm, 2'b00};
    case (k)
      4'd1:        return (a == b) ? br : nxt;
      4'd2:        return (a != b) ? br : nxt;
      4'd3:        return (!a[31]) ? br : nxt;
      4'd4:        return (a[31] || a == 0) ? br : nxt;
      4'd5:        return (a[31]) ? br : nxt;
      4'd6:        return (!a[31] && a != 0) ? br : nxt;
      4'd7, 4'd8:  return {pc[31:28], tgt, 2'b00};
      4'd9, 4'd10: return a;
      default:     return nxt;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic [25:0] tgt);
    req_kind = k; req_pc = pc; req_opa = a; req_opb = b; req_imm = imm; req_tgt = tgt;
    req_valid = 1'b1;
  endtask

  // one request, result checked after the accepting edge
  task automatic send(input string tag, input logic [3:0] k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
      input logic [25:0] tgt);
    logic lnk;
    @(negedge clk);
    drive(k, pc, a, b, imm, tgt);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lnk = (k == 4'd8 || k == 4'd10);
    chk({tag, " R8 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " pc"}, res_pc, ref_pc(k, pc, a, b, imm, tgt));
    chk({tag, " R6 link_we"}, 32'(res_link_we), 32'(lnk));
    if (lnk) begin
      chk({tag, " R6 link_val"}, res_link_val, pc + 32'd4);
      chk({tag, " R6 link_idx"}, 32'(res_link_idx), 32'd31);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", 32'(res_valid), 32'd0);
    chk("R9 reset ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;

    send("R1 seq", 4'd0, 32'h0000_1000, 0, 0, 16'h7fff, 26'h3ff_ffff);
    send("R1 unused code", 4'd13, 32'h0040_0020, 5, 5, 16'h0010, 26'h1);
    send("R7 seq wrap", 4'd0, 32'hffff_fffc, 0, 0, 0, 0);
    send("R2 eq taken fwd", 4'd1, 32'h0000_0100, 32'h55, 32'h55, 16'h0004, 0);
    send("R2 eq taken back", 4'd1, 32'h0000_0110, 7, 7, 16'hfffc, 0);
    send("R2 eq not taken", 4'd1, 32'h0000_0110, 7, 8, 16'hfffc, 0);
    send("R2 ne taken", 4'd2, 32'h0000_2000, 1, 2, 16'h8000, 0);
    send("R7 branch wrap", 4'd1, 32'h0000_0004, 0, 0, 16'hfffc, 0);
    send("R3 gez zero", 4'd3, 32'h0000_0200, 0, 0, 16'h0008, 0);
    send("R3 lez zero", 4'd4, 32'h0000_0200, 0, 0, 16'h0008, 0);
    send("R3 ltz zero", 4'd5, 32'h0000_0200, 0, 0, 16'h0008, 0);
    send("R3 gtz zero", 4'd6, 32'h0000_0200, 0, 0, 16'h0008, 0);
    send("R3 ltz minneg", 4'd5, 32'h0000_0300, 32'h8000_0000, 0, 16'h0003, 0);
    send("R3 gtz minneg", 4'd6, 32'h0000_0300, 32'h8000_0000, 0, 16'h0003, 0);
    send("R3 gtz maxpos", 4'd6, 32'h0000_0300, 32'h7fff_ffff, 0, 16'h0003, 0);
    send("R4 jump", 4'd7, 32'h5000_0040, 0, 0, 0, 26'h000_0475);
    send("R4 jump link", 4'd8, 32'ha123_4568, 0, 0, 0, 26'h3ff_ffff);
    send("R5 reg jump", 4'd9, 32'h0000_0400, 32'h1234_5677, 0, 0, 0);
    send("R5 reg jump link", 4'd10, 32'hffff_fffc, 32'h0000_8000, 0, 0, 0);

    // R8: back-pressure with a second request waiting
    @(negedge clk);
    res_ready = 1'b0;
    drive(4'd8, 32'h0000_0800, 0, 0, 0, 26'h10);
    @(posedge clk);
    @(negedge clk);
    held = ref_pc(4'd8, 32'h0000_0800, 0, 0, 0, 26'h10);
    chk("R8 ready low when full", 32'(req_ready), 32'd0);
    drive(4'd9, 32'h0000_0900, 32'hcafe_f00c, 0, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 held pc", res_pc, held);
    chk("R8 held valid", 32'(res_valid), 32'd1);
    chk("R8 held link", 32'(res_link_we), 32'd1);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 waiting req next", res_pc, 32'hcafe_f00c);
    chk("R6 no link on reg jump", 32'(res_link_we), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 drained", 32'(res_valid), 32'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] k;
      logic [31:0] a, b;
      k = 4'($urandom_range(0, 15));
      a = $urandom;
      case ($urandom_range(0, 3))
        0: a = 0;
        1: a = {a[31], 31'h0};
        default: ;
      endcase
      b = ($urandom_range(0, 1) == 0) ? a : $urandom;
      send("R1-mix random", k, $urandom, a, b, 16'($urandom), 26'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule